// File: doc/BRIEF.md
# Character Port Register Front End

This block sits between an embedded processor's register bus and a byte-wide character link to a host. It holds two queues. The receive queue is filled by the host and drained by software. The transmit queue is filled by software and drained by the host. Software sees two 32-bit words. Address 0 is the data word: reading it pops one received character, and writing it queues one character for transmit. Address 1 is the control/status word: it holds the interrupt enables, the pending flags, a sticky host-activity flag and the free space in the transmit queue.

The host side uses plain valid/ready byte streams and a one-cycle activity strobe. A single level interrupt is raised while an enabled condition holds. The read condition is that enough characters are waiting. The write condition is that enough transmit space is free. Queue depth and both thresholds are parameters.

Top module: `char_port_regs`

## Requirements
- R1: A bus read of address 0 with the receive queue non-empty returns the oldest received character in bits 7:0 and a 1 in bit 15. It removes that character, so the next read returns the following one.
- R2: A bus read of address 0 with the receive queue empty returns 0 in bits 15:0 and removes nothing. A character pushed afterwards is the next one returned.
- R3: Bits 31:16 of a data read hold the number of receive characters left after this read has taken effect. A host push in the same cycle is not counted.
- R4: A bus write to address 0 queues bits 7:0 for transmit. The host stream tx_data_o/tx_valid_o presents the queued characters in write order, one per cycle in which tx_ready_i is high.
- R5: A data write while the transmit queue is full is dropped without any indication. The queue contents and the free count are unchanged.
- R6: Control bit 0 (read enable) and bit 1 (write enable) are written from the write data and read back as written. Both reset to 0.
- R7: Control bit 8 reads 1 exactly when bit 0 is set and the receive count is at least RD_THR. Control bit 9 reads 1 exactly when bit 1 is set and the transmit free count is at least WR_THR.
- R8: irq_o is high exactly when control bit 8 or bit 9 would read 1. It follows the state with no added delay.
- R9: Control bit 10 becomes 1 in the cycle after host_act_i is high. It stays 1 until a control write with bit 10 set clears it. A control write with bit 10 clear leaves it unchanged.
- R10: When host_act_i and a clearing control write occur in the same cycle, bit 10 ends up 1.
- R11: Control bits 31:16 read the number of free transmit entries.
- R12: A control write affects only bits 0, 1 and 10. Bits 8, 9 and 31:16 ignore written values, and the bits not assigned above always read 0.
- R13: A bus read presents its word on rdata_o with rvalid_o high in the cycle after the request. Writes produce no rvalid_o.
- R14: rx_ready_o is low exactly while the receive queue is full. A host character offered then is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus request, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 1 | 0 = data word, 1 = control word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rx_valid_i | input | 1 | Host offers a receive character |
| rx_data_i | input | 8 | Receive character |
| rx_ready_o | output | 1 | Receive queue can accept |
| tx_valid_o | output | 1 | Transmit character available |
| tx_data_o | output | 8 | Oldest transmit character |
| tx_ready_i | input | 1 | Host takes the transmit character |
| host_act_i | input | 1 | Host activity strobe |
| irq_o | output | 1 | Level interrupt |

## Verification
Read words are registered, so each one is due in the cycle after its request. The driver therefore queues the expected word when it issues the read. The monitor pops and compares on the falling edge after rvalid_o rises. The interrupt, the ready/valid flags and the transmit head follow the registered state combinationally. They are checked on the falling edge after the clock edge that changed that state. The expected values come from a model of both queues and the control bits that the bench keeps itself.

// File: rtl/char_port_pkg.sv
package char_port_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;
  localparam int unsigned BIT_RE    = 0;
  localparam int unsigned BIT_WE    = 1;
  localparam int unsigned BIT_RP    = 8;
  localparam int unsigned BIT_WP    = 9;
  localparam int unsigned BIT_ACT   = 10;
  localparam int unsigned BIT_VALID = 15;
endpackage

// File: rtl/char_fifo.sv
module char_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem[rptr_q];
  assign count_o = count_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= nxt(wptr_q);
      if (do_pop)  rptr_q <= nxt(rptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R5
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  // R5
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && $stable(wptr_q)));
endmodule

// File: rtl/char_port_irq.sv
module char_port_irq #(
  parameter int unsigned CW     = 4,
  parameter int unsigned RD_THR = 1,
  parameter int unsigned WR_THR = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] rx_count_i,
  input  logic [CW-1:0] tx_free_i,
  input  logic          rd_en_i,
  input  logic          wr_en_i,
  output logic          rd_pend_o,
  output logic          wr_pend_o,
  output logic          irq_o
);
  assign rd_pend_o = rd_en_i && (32'(rx_count_i) >= RD_THR);
  assign wr_pend_o = wr_en_i && (32'(tx_free_i) >= WR_THR);
  assign irq_o     = rd_pend_o || wr_pend_o;

  // R8
  irq_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (rd_en_i || wr_en_i));
endmodule

// File: rtl/char_port_regs.sv
module char_port_regs
  import char_port_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned RD_THR = 1,
  parameter int unsigned WR_THR = 4,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        rvalid_o,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  input  logic        host_act_i,
  output logic        irq_o
);
  logic [CW-1:0] rx_count, tx_count, tx_free, rx_left;
  logic [7:0]    rx_head;
  logic          rx_full, rx_empty, tx_full, tx_empty;
  logic          rd_acc, data_rd, data_wr, ctrl_wr, rx_pop;
  logic          re_q, we_q, act_q, rd_pend, wr_pend;
  logic [31:0]   rd_word;
  logic          wdata_unused;

  assign rd_acc  = req_i && !we_i;
  assign data_rd = rd_acc && (addr_i == ADDR_DATA);
  assign data_wr = req_i && we_i && (addr_i == ADDR_DATA);
  assign ctrl_wr = req_i && we_i && (addr_i == ADDR_CTRL);
  assign rx_pop  = data_rd && !rx_empty;
  assign wdata_unused = ^{wdata_i[31:11], wdata_i[9:2]};

  char_fifo #(.W(8), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni,
    .push_i(rx_valid_i), .data_i(rx_data_i), .pop_i(rx_pop),
    .data_o(rx_head), .count_o(rx_count), .full_o(rx_full), .empty_o(rx_empty)
  );

  char_fifo #(.W(8), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni,
    .push_i(data_wr), .data_i(wdata_i[7:0]), .pop_i(tx_ready_i),
    .data_o(tx_data_o), .count_o(tx_count), .full_o(tx_full), .empty_o(tx_empty)
  );

  assign rx_ready_o = !rx_full;
  assign tx_valid_o = !tx_empty;
  assign tx_free    = CW'(DEPTH) - tx_count;
  assign rx_left    = rx_count - CW'(rx_pop);

  char_port_irq #(.CW(CW), .RD_THR(RD_THR), .WR_THR(WR_THR)) u_irq (
    .clk_i, .rst_ni,
    .rx_count_i(rx_count), .tx_free_i(tx_free),
    .rd_en_i(re_q), .wr_en_i(we_q),
    .rd_pend_o(rd_pend), .wr_pend_o(wr_pend), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_q  <= 1'b0;
      we_q  <= 1'b0;
      act_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        re_q <= wdata_i[BIT_RE];
        we_q <= wdata_i[BIT_WE];
      end
      // set beats clear
      if (host_act_i)                        act_q <= 1'b1;
      else if (ctrl_wr && wdata_i[BIT_ACT])  act_q <= 1'b0;
    end
  end

  always_comb begin
    rd_word = '0;
    if (addr_i == ADDR_DATA) begin
      rd_word[31:16] = 16'(rx_left);
      if (!rx_empty) begin
        rd_word[BIT_VALID] = 1'b1;
        rd_word[7:0]       = rx_head;
      end
    end else begin
      rd_word[31:16]   = 16'(tx_free);
      rd_word[BIT_RE]  = re_q;
      rd_word[BIT_WE]  = we_q;
      rd_word[BIT_RP]  = rd_pend;
      rd_word[BIT_WP]  = wr_pend;
      rd_word[BIT_ACT] = act_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_acc;
      if (rd_acc) rdata_o <= rd_word;
    end
  end

  // R13
  rvalid_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  // R13
  no_write_rvalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_i || we_i) |=> !rvalid_o);
  // R10
  act_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_act_i |=> act_q);
  // R9
  act_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && !(ctrl_wr && wdata_i[BIT_ACT])) |=> act_q);
  // R2
  empty_read_no_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_rd && rx_empty) |=> (rvalid_o && !rdata_o[BIT_VALID] && rdata_o[7:0] == 8'h00));
endmodule

// File: tb/char_port_regs_tb.sv
module char_port_regs_tb;
  localparam int unsigned DEPTH  = 8;
  localparam int unsigned RD_THR = 1;
  localparam int unsigned WR_THR = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0, addr = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, tx_ready = 0, host_act = 0, irq;
  logic [7:0]  tx_data;

  int checks = 0;
  int errors = 0;

  logic [7:0]  rx_m[$];
  logic [7:0]  tx_m[$];
  logic        re_m = 0, we_m = 0, act_m = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  char_port_regs #(.DEPTH(DEPTH), .RD_THR(RD_THR), .WR_THR(WR_THR)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .host_act_i(host_act), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic rp_m();
    return re_m && (rx_m.size() >= RD_THR);
  endfunction
  function automatic logic wp_m();
    return we_m && ((DEPTH - tx_m.size()) >= WR_THR);
  endfunction
  function automatic logic [31:0] ctrl_m();
    logic [31:0] v = '0;
    v[31:16] = 16'(DEPTH - tx_m.size());
    v[0] = re_m; v[1] = we_m; v[8] = rp_m(); v[9] = wp_m(); v[10] = act_m;
    return v;
  endfunction

  // monitor: pops expected read words as they appear
  always @(negedge clk) begin
    if (rst_n && rvalid) begin
      if (exp_q.size() == 0) chk(1'b0, "R13 unexpected rvalid", rdata, 32'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata === e, t, rdata, e);
      end
    end
  end

  task automatic bus_read(input logic a, input string tag);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    if (a == 1'b0) begin
      logic [31:0] e = '0;
      if (rx_m.size() != 0) begin
        e[7:0] = rx_m.pop_front();
        e[15]  = 1'b1;
      end
      e[31:16] = 16'(rx_m.size());
      exp_q.push_back(e);
    end else exp_q.push_back(ctrl_m());
    tag_q.push_back(tag);
    @(posedge clk);
    #1 req = 0;
  endtask

  task automatic bus_write(input logic a, input logic [31:0] d, input logic act);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d; host_act = act;
    if (a == 1'b0) begin
      if (tx_m.size() < DEPTH) tx_m.push_back(d[7:0]);
    end else begin
      re_m = d[0]; we_m = d[1];
      if (d[10]) act_m = 0;
    end
    if (act) act_m = 1;
    @(posedge clk);
    #1 req = 0; we = 0; host_act = 0;
  endtask

  task automatic host_push(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    if (rx_m.size() < DEPTH) rx_m.push_back(b);
    @(posedge clk);
    #1 rx_valid = 0;
  endtask

  task automatic host_pull(input string tag);
    @(negedge clk);
    if (tx_m.size() == 0) chk(tx_valid == 1'b0, tag, 32'(tx_valid), 32'h0);
    else begin
      logic [7:0] e = tx_m.pop_front();
      chk(tx_valid && tx_data == e, tag, {23'h0, tx_valid, tx_data}, {24'h1, e});
      tx_ready = 1;
      @(posedge clk);
      #1 tx_ready = 0;
    end
  endtask

  task automatic chk_irq(input string tag);
    @(negedge clk);
    chk(irq == (rp_m() || wp_m()), tag, 32'(irq), 32'(rp_m() || wp_m()));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state (R6 R13 R14)
    chk(irq == 0 && tx_valid == 0 && rx_ready == 1 && rvalid == 0, "R6 reset outputs",
        {28'h0, irq, tx_valid, rx_ready, rvalid}, 32'h2);
    rst_n = 1;
    bus_read(1'b1, "R11 reset control word");
    bus_read(1'b0, "R2 empty read");
    host_push(8'hA1); host_push(8'hB2); host_push(8'hC3);
    bus_read(1'b0, "R1 R3 first pop");
    host_push(8'hD4);
    bus_read(1'b0, "R1 R3 second pop");
    bus_write(1'b1, 32'h1, 1'b0);
    chk_irq("R8 read irq enabled");
    bus_read(1'b1, "R6 R7 read pending");
    bus_read(1'b0, "R3 pop leaves one");
    bus_read(1'b0, "R3 pop leaves zero");
    chk_irq("R7 read irq drops when empty");
    bus_read(1'b0, "R2 empty after drain");
    host_push(8'h5A);
    bus_read(1'b0, "R2 no pop on empty read");
    bus_write(1'b1, 32'h2, 1'b0);
    chk_irq("R8 write irq enabled");
    for (int i = 0; i < 5; i++) bus_write(1'b0, 32'h10 + 32'(i), 1'b0);
    chk_irq("R7 write irq below threshold");
    bus_read(1'b1, "R11 free after five");
    for (int i = 5; i < 8; i++) bus_write(1'b0, 32'h10 + 32'(i), 1'b0);
    bus_write(1'b0, 32'hEE, 1'b0);
    bus_read(1'b1, "R5 full free zero");
    for (int i = 0; i < 9; i++) host_pull("R4 R5 tx order");
    chk_irq("R8 write irq after drain");
    // activity flag
    @(negedge clk); host_act = 1; act_m = 1;
    @(posedge clk); #1 host_act = 0;
    bus_read(1'b1, "R9 activity set");
    bus_write(1'b1, 32'h3, 1'b0);
    bus_read(1'b1, "R9 write 0 keeps flag");
    bus_write(1'b1, 32'h403, 1'b0);
    bus_read(1'b1, "R9 write 1 clears flag");
    bus_write(1'b1, 32'h400, 1'b1);
    bus_read(1'b1, "R10 set wins over clear");
    bus_write(1'b1, 32'hFFFF_FFFF, 1'b0);
    bus_read(1'b1, "R12 only bits 0 1 10 written");
    chk_irq("R8 irq with both enables");
    // receive overflow
    for (int i = 0; i < DEPTH + 1; i++) host_push(8'h60 + 8'(i));
    @(negedge clk);
    chk(rx_ready == 1'b0, "R14 ready low when full", 32'(rx_ready), 32'h0);
    for (int i = 0; i < DEPTH + 1; i++) bus_read(1'b0, "R14 R1 rx drain");
    @(negedge clk);
    chk(rx_ready == 1'b1, "R14 ready back", 32'(rx_ready), 32'h1);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R13 all reads returned", 32'(exp_q.size()), 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule